// File: doc/BRIEF.md
# Reset Configuration Byte Loader

This block is the first agent on the memory bus after reset. Once reset is released it reads a small set of configuration bytes from fixed addresses through a single read port. Each read waits for a ready handshake. The bytes go into configuration registers that stay frozen until the next reset. While a byte has not yet arrived, its register holds all ones. That value is the most conservative setting: slowest bus, most wait states. When the last byte is in, the block raises a done flag and presents the address of the first instruction fetch to the core.

A mode input picks the set of source addresses. In normal operation the bytes come from 2018H and 201AH. In programming mode they come from an alternate base, 0018H and 001AH by default. The mode is sampled once, on the first clock edge after reset is released. The meaning of the individual configuration bits is left to the blocks that consume them.

Any attempt to rewrite the configuration registers is refused. An attempt made after loading has finished also raises a one-cycle lock-violation pulse.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is asserted, rd_req_o is 0, load_done_o is 0, lock_viol_o is 0, fetch_addr_o is 0000H and every configuration byte reads FFH.
- R2: In normal mode, rd_req_o rises on the first clock edge after reset release, with rd_addr_o = 2018H.
- R3: While rd_req_o is 1 and rd_ready_i is 0, rd_req_o and rd_addr_o hold. On an edge where both are 1, rd_data_i is stored into the byte being fetched (byte k at cfg_o bits [8k+7:8k]).
- R4: The cycle after the first byte is accepted, the block requests the second byte at rd_addr_o = 201AH.
- R5: If prog_mode_i is 1 at the first edge after reset release, the reads go to 0018H and then 001AH.
- R6: Changes on prog_mode_i after that first edge do not alter the addresses used.
- R7: Each configuration byte reads FFH until its own fetch is accepted.
- R8: On the edge that accepts the last byte, load_done_o goes to 1 and rd_req_o goes to 0. fetch_addr_o then reads 2080H, and reads 0000H before that.
- R9: Once load_done_o is 1, cfg_o stays unchanged and load_done_o stays 1 until reset, whatever happens on rd_ready_i, rd_data_i and cfg_wr_try_i.
- R10: A cycle with cfg_wr_try_i = 1 while load_done_o is 1 makes lock_viol_o equal 1 in the following cycle, once for each such cycle. Attempts made before load_done_o is 1 leave cfg_o unchanged and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_mode_i | input | 1 | 1 selects the programming-mode source addresses |
| rd_data_i | input | DATA_W (8) | Read data from memory |
| rd_ready_i | input | 1 | Read data valid / read accepted |
| cfg_wr_try_i | input | 1 | Attempt to rewrite the configuration registers |
| rd_addr_o | output | ADDR_W (16) | Read address |
| rd_req_o | output | 1 | Read strobe |
| cfg_o | output | NUM_CFG*DATA_W (16) | Configuration register contents, byte 0 in the low bits |
| load_done_o | output | 1 | Loading finished, registers locked |
| fetch_addr_o | output | ADDR_W (16) | First instruction fetch address once done |
| lock_viol_o | output | 1 | One-cycle pulse for a refused write after done |

## Verification
Two functions can meet in one cycle: the loader storing a fetched byte, and a write attempt on cfg_wr_try_i. The bench provokes this by holding the write attempt through the wait cycles and through the accepting edge of both fetches. It then expects the fetched data to land, and no violation pulse to follow, because done is not yet set at that edge. A second meeting happens after done, when ready pulses carrying random data arrive in the same cycles as write attempts. There each attempt must produce exactly one pulse, and the stored bytes must not move.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_FETCH = 2'd1,
      LD_DONE  = 2'd2
   } ld_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
   import cfgld_pkg::*;
#(
   parameter int NUM_CFG = 2,
   parameter int IDX_W   = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_i,
   input  logic             rd_ready_i,
   output logic             rd_req_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             mode_q_o,
   output logic             cap_o,
   output logic             done_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CFG - 1);

   ld_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LD_IDLE;
         idx_q   <= '0;
         mode_q  <= 1'b0;
      end else begin
         case (state_q)
            LD_IDLE: begin
               mode_q  <= mode_i;
               idx_q   <= '0;
               state_q <= LD_FETCH;
            end
            LD_FETCH: begin
               if (rd_ready_i) begin
                  if (idx_q == LAST_IDX) state_q <= LD_DONE;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            default: state_q <= LD_DONE;
         endcase
      end
   end

   assign rd_req_o = (state_q == LD_FETCH);
   assign cap_o    = (state_q == LD_FETCH) && rd_ready_i;
   assign done_o   = (state_q == LD_DONE);
   assign idx_o    = idx_q;
   assign mode_q_o = mode_q;

   assert_hold_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(idx_o)));

   assert_mode_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != LD_IDLE) |=> $stable(mode_q_o));

   assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (done_o && !rd_req_o));

endmodule

// File: rtl/cfgld_addr_gen.sv
module cfgld_addr_gen #(
   parameter int              ADDR_W    = 16,
   parameter int              IDX_W     = 1,
   parameter int              STRIDE    = 2,
   parameter bit              PROG_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] NORM_BASE = 16'h2018,
   parameter logic [ADDR_W-1:0] PROG_BASE = 16'h0018
) (
   input  logic              mode_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] base;

   generate
      if (PROG_EN) begin : g_dual_base
         assign base = mode_i ? PROG_BASE : NORM_BASE;
      end else begin : g_single_base
         logic unused_mode;
         assign unused_mode = mode_i;
         assign base        = NORM_BASE;
      end
   endgenerate

   assign addr_o = base + (ADDR_W'(idx_i) * ADDR_W'(STRIDE));

endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank #(
   parameter int              DATA_W  = 8,
   parameter int              NUM_CFG = 2,
   parameter int              IDX_W   = 1,
   parameter logic [DATA_W-1:0] SAFE_VAL = '1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      load_en_i,
   input  logic [IDX_W-1:0]          load_idx_i,
   input  logic [DATA_W-1:0]         load_data_i,
   input  logic                      locked_i,
   output logic [NUM_CFG*DATA_W-1:0] cfg_o
);

   generate
      for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               q <= SAFE_VAL;
            else if (load_en_i && !locked_i && (load_idx_i == IDX_W'(i)))
               q <= load_data_i;
         end
         assign cfg_o[i*DATA_W +: DATA_W] = q;
      end
   endgenerate

   assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_i |=> $stable(cfg_o));

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
   import cfgld_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              DATA_W    = 8,
   parameter int              NUM_CFG   = 2,
   parameter int              STRIDE    = 2,
   parameter bit              PROG_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] NORM_BASE = 16'h2018,
   parameter logic [ADDR_W-1:0] PROG_BASE = 16'h0018,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h2080
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      prog_mode_i,
   input  logic [DATA_W-1:0]         rd_data_i,
   input  logic                      rd_ready_i,
   input  logic                      cfg_wr_try_i,
   output logic [ADDR_W-1:0]         rd_addr_o,
   output logic                      rd_req_o,
   output logic [NUM_CFG*DATA_W-1:0] cfg_o,
   output logic                      load_done_o,
   output logic [ADDR_W-1:0]         fetch_addr_o,
   output logic                      lock_viol_o
);

   localparam int IDX_W = idx_width(NUM_CFG);

   generate
      if (ADDR_W < 2 || DATA_W < 1 || NUM_CFG < 1 || STRIDE < 1) begin : g_bad_params
         $error("cfg_boot_loader: illegal parameter set");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             mode_q;
   logic             cap;
   logic             done;
   logic             viol_q;

   cfgld_seq #(
      .NUM_CFG (NUM_CFG),
      .IDX_W   (IDX_W)
   ) seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (prog_mode_i),
      .rd_ready_i (rd_ready_i),
      .rd_req_o   (rd_req_o),
      .idx_o      (idx),
      .mode_q_o   (mode_q),
      .cap_o      (cap),
      .done_o     (done)
   );

   cfgld_addr_gen #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .STRIDE    (STRIDE),
      .PROG_EN   (PROG_EN),
      .NORM_BASE (NORM_BASE),
      .PROG_BASE (PROG_BASE)
   ) addr_i (
      .mode_i (mode_q),
      .idx_i  (idx),
      .addr_o (rd_addr_o)
   );

   cfgld_bank #(
      .DATA_W  (DATA_W),
      .NUM_CFG (NUM_CFG),
      .IDX_W   (IDX_W)
   ) bank_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_en_i   (cap),
      .load_idx_i  (idx),
      .load_data_i (rd_data_i),
      .locked_i    (done),
      .cfg_o       (cfg_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) viol_q <= 1'b0;
      else         viol_q <= done && cfg_wr_try_i;
   end

   assign load_done_o  = done;
   assign lock_viol_o  = viol_q;
   assign fetch_addr_o = done ? BOOT_ADDR : '0;

   assert_viol_only_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_viol_o |-> load_done_o);

   assert_done_after_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(load_done_o) |-> $past(rd_ready_i && rd_req_o));

   assert_no_req_when_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_done_o |-> !rd_req_o);

endmodule

// File: tb/cfg_boot_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        prog_mode_i = 1'b0;
   logic [7:0]  rd_data_i = '0;
   logic        rd_ready_i = 1'b0;
   logic        cfg_wr_try_i = 1'b0;
   logic [15:0] rd_addr_o;
   logic        rd_req_o;
   logic [15:0] cfg_o;
   logic        load_done_o;
   logic [15:0] fetch_addr_o;
   logic        lock_viol_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [7:0] exp_cfg [2];

   always #4 clk_i = ~clk_i;

   cfg_boot_loader dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .prog_mode_i  (prog_mode_i),
      .rd_data_i    (rd_data_i),
      .rd_ready_i   (rd_ready_i),
      .cfg_wr_try_i (cfg_wr_try_i),
      .rd_addr_o    (rd_addr_o),
      .rd_req_o     (rd_req_o),
      .cfg_o        (cfg_o),
      .load_done_o  (load_done_o),
      .fetch_addr_o (fetch_addr_o),
      .lock_viol_o  (lock_viol_o)
   );

   function automatic logic [15:0] exp_addr(input bit mode, input int k);
      return (mode ? 16'h0018 : 16'h2018) + 16'(2 * k);
   endfunction

   function automatic string addr_req(input bit mode, input bit flip, input int k);
      if (flip)  return "R6";
      if (mode)  return "R5";
      return (k == 0) ? "R2" : "R4";
   endfunction

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk_i);
      rst_ni = 1'b0;
      rd_ready_i = 1'b0;
      cfg_wr_try_i = 1'b0;
      #1;
      check_eq("R1", "req in reset", rd_req_o, 0);
      check_eq("R1", "done in reset", load_done_o, 0);
      check_eq("R1", "viol in reset", lock_viol_o, 0);
      check_eq("R1", "fetch addr in reset", fetch_addr_o, 0);
      check_eq("R1", "cfg in reset", cfg_o, 16'hFFFF);
      repeat (2) @(negedge clk_i);
   endtask

   task automatic run_boot(input bit mode, input int lat0, input int lat1,
                           input bit flip, input bit early_wr);
      do_reset();
      prog_mode_i = mode;
      rst_ni = 1'b1;
      @(negedge clk_i);
      for (int k = 0; k < 2; k++) begin
         int lat;
         logic [7:0] v;
         lat = (k == 0) ? lat0 : lat1;
         v = 8'($urandom);
         for (int w = 0; w < lat; w++) begin
            check_eq("R3", "req held while waiting", rd_req_o, 1);
            check_eq(addr_req(mode, flip, k), "addr while waiting", rd_addr_o, exp_addr(mode, k));
            check_eq("R7", "pending byte safe", cfg_o[k*8 +: 8], 8'hFF);
            check_eq("R8", "fetch addr before done", fetch_addr_o, 0);
            if (early_wr) check_eq("R10", "no viol before done", lock_viol_o, 0);
            if (flip) prog_mode_i = ~prog_mode_i;
            if (early_wr) cfg_wr_try_i = 1'b1;
            @(negedge clk_i);
         end
         check_eq("R3", "req present", rd_req_o, 1);
         check_eq(addr_req(mode, flip, k), "fetch address", rd_addr_o, exp_addr(mode, k));
         check_eq("R7", "byte safe before accept", cfg_o[k*8 +: 8], 8'hFF);
         rd_ready_i = 1'b1;
         rd_data_i = v;
         if (early_wr) cfg_wr_try_i = 1'b1;
         @(negedge clk_i);
         rd_ready_i = 1'b0;
         rd_data_i = 8'($urandom);
         cfg_wr_try_i = 1'b0;
         exp_cfg[k] = v;
         check_eq("R3", "byte captured", cfg_o[k*8 +: 8], v);
         if (k == 0) begin
            check_eq("R7", "second byte still safe", cfg_o[15:8], 8'hFF);
            check_eq("R8", "not done after first", load_done_o, 0);
         end
      end
      check_eq("R8", "done after last", load_done_o, 1);
      check_eq("R8", "req dropped", rd_req_o, 0);
      check_eq("R8", "boot fetch addr", fetch_addr_o, 16'h2080);
      check_eq("R10", "no viol at final capture", lock_viol_o, 0);
      check_eq("R3", "cfg after load", cfg_o, {exp_cfg[1], exp_cfg[0]});
   endtask

   task automatic post_done(input int n);
      for (int i = 0; i < n; i++) begin
         bit wr;
         wr = 1'($urandom);
         cfg_wr_try_i = wr;
         rd_ready_i = 1'($urandom);
         rd_data_i = 8'($urandom);
         @(negedge clk_i);
         cfg_wr_try_i = 1'b0;
         rd_ready_i = 1'b0;
         check_eq("R10", "viol follows attempt", lock_viol_o, wr);
         check_eq("R9", "cfg frozen", cfg_o, {exp_cfg[1], exp_cfg[0]});
         check_eq("R9", "done sticky", load_done_o, 1);
      end
      @(negedge clk_i);
      check_eq("R10", "viol clears", lock_viol_o, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0C0B));
      run_boot(1'b0, 0, 0, 1'b0, 1'b0);
      post_done(4);
      run_boot(1'b1, 0, 0, 1'b0, 1'b0);
      post_done(4);
      run_boot(1'b0, 2, 3, 1'b0, 1'b1);
      post_done(4);
      run_boot(1'b1, 3, 2, 1'b1, 1'b0);
      run_boot(1'b0, 2, 1, 1'b1, 1'b1);
      post_done(3);
      for (int r = 0; r < 10; r++) begin
         run_boot(1'($urandom), int'($urandom_range(0, 4)), int'($urandom_range(0, 4)),
                  1'($urandom), 1'($urandom));
         post_done(int'($urandom_range(2, 6)));
      end
      finish_run();
   end

endmodule